// File: doc/BRIEF.md
# Output Hazard Classification Monitor

This block is a synchronous checker for one output of an asynchronous circuit under test. It samples the circuit's input bus and that single output on every clock. It assumes the fundamental mode of operation: the environment changes one input, then waits until the circuit has settled. Each time an input changes, the block opens an observation window and counts the output transitions that occur before the circuit is judged stable. The circuit is judged stable once a programmable number of consecutive samples shows no output change.

When the window closes, the parity of the count classifies the result. An even count of two or more means the output pulsed and came back, which is a static hazard. An odd count of three or more means the output wobbled before it reached its new value, which is a dynamic hazard. Three other conditions raise flags as they happen: a sample in which several input bits changed together, an input change that arrives while a window is still open, and an output that exceeds a programmable transition limit inside one window. All four flags stay set until the clear input is pulsed. A circuit with several outputs uses one instance per output.

Top module: `hazard_monitor`

## Requirements
- R1: After reset all four flags and the window indicator busy_o are low, and the stored reference samples of the input bus and the output are zero.
- R2: An input sample differing from the previous one in exactly one bit opens a window, and busy_o is high after that edge. The window closes, and busy_o falls, at the first edge where settle_cycles_i consecutive samples have shown no output change since the last counted change. A window with zero or one output change sets no flag.
- R3: A sample in which two or more input bits differ from the previous sample sets mode_viol_o at that edge.
- R4: An input change sampled while a window is open sets mode_viol_o at that edge and restarts the window.
- R5: A window that closes with an even output-change count of two or more sets static_haz_o at its closing edge.
- R6: A window that closes with an odd output-change count of three or more sets dynamic_haz_o at its closing edge.
- R7: At the edge where the output-change count of the current window first exceeds osc_limit_i, osc_o is set. The count saturates at its maximum.
- R8: Flags are sticky. An edge with clr_i high clears all four flags, and the clear wins over any flag set at the same edge. clr_i does not affect the window.
- R9: An output change sampled while no window is open opens a window with a count of one. Later changes add to that count, and it is classified under R5 and R6.
- R10: A settle_cycles_i value of zero behaves as one.
- R11: A window ended early by an input change (R4) is classified by the count it had reached, and static_haz_o or dynamic_haz_o is set at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | IN_W | Sampled input bus of the circuit under test |
| out_i | input | 1 | Sampled output under observation |
| settle_cycles_i | input | SETTLE_W | Number of quiet samples after which the circuit counts as stable |
| osc_limit_i | input | CNT_W | Highest output-change count in one window that is tolerated |
| clr_i | input | 1 | Clears all flags |
| busy_o | output | 1 | High while an observation window is open |
| mode_viol_o | output | 1 | Sticky fundamental-mode violation flag |
| static_haz_o | output | 1 | Sticky static hazard flag |
| dynamic_haz_o | output | 1 | Sticky dynamic hazard flag |
| osc_o | output | 1 | Sticky oscillation flag |

## Verification
Each flag is registered at the same edge that samples its cause, so mode_viol_o and osc_o are checked one negative edge after the stimulus is driven. For the hazard flags and busy_o, the bench counts settle_cycles_i quiet edges from the last output toggle. It checks that busy_o is still high one edge before the close and low one edge after it, and reads the hazard flags only after the close. Sweeps cover the settle setting, the number of output toggles and the gap between toggles, and the expected flags come from the parity of the toggle count.

// File: rtl/hazmon_pkg.sv
package hazmon_pkg;
  typedef struct packed {
    logic mode_viol;
    logic static_haz;
    logic dynamic_haz;
    logic osc;
  } haz_flags_t;
endpackage

// File: rtl/hm_edge.sv
module hm_edge #(
  parameter int IN_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] in_i,
  input  logic            out_i,
  output logic [IN_W-1:0] in_prev_o,
  output logic            out_prev_o,
  output logic            in_chg_o,
  output logic            multi_chg_o,
  output logic            out_chg_o
);
  localparam int PC_W = $clog2(IN_W + 1);

  logic [IN_W-1:0] diff;
  logic [PC_W-1:0] n_diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_prev_o  <= '0;
      out_prev_o <= 1'b0;
    end else begin
      in_prev_o  <= in_i;
      out_prev_o <= out_i;
    end
  end

  assign diff = in_i ^ in_prev_o;

  always_comb begin
    n_diff = '0;
    for (int i = 0; i < IN_W; i++) n_diff = n_diff + PC_W'(diff[i]);
  end

  assign in_chg_o    = |diff;
  assign multi_chg_o = n_diff > PC_W'(1);
  assign out_chg_o   = out_i ^ out_prev_o;
endmodule

// File: rtl/hm_window.sv
module hm_window #(
  parameter int CNT_W    = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_chg_i,
  input  logic                out_chg_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic [CNT_W-1:0]    osc_limit_i,
  output logic                active_o,
  output logic                early_in_o,
  output logic                close_o,
  output logic [CNT_W-1:0]    close_cnt_o,
  output logic                osc_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SETTLE_W-1:0] quiet_q, quiet_d;
  logic [SETTLE_W:0]   quiet_p1, settle_eff;
  logic                active_d, settled;

  // zero settle count behaves as one
  assign settle_eff = (settle_cycles_i == '0) ? (SETTLE_W+1)'(1)
                                              : {1'b0, settle_cycles_i};
  assign quiet_p1   = {1'b0, quiet_q} + (SETTLE_W+1)'(1);
  assign settled    = active_o && !in_chg_i && !out_chg_i && (quiet_p1 >= settle_eff);

  always_comb begin
    cnt_d    = cnt_q;
    quiet_d  = quiet_q;
    active_d = active_o;
    if (in_chg_i) begin
      cnt_d    = CNT_W'(out_chg_i);
      quiet_d  = '0;
      active_d = 1'b1;
    end else if (out_chg_i) begin
      cnt_d    = !active_o ? CNT_W'(1) : (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);
      quiet_d  = '0;
      active_d = 1'b1;
    end else if (settled) begin
      active_d = 1'b0;
    end else if (active_o && quiet_q != {SETTLE_W{1'b1}}) begin
      quiet_d = quiet_q + SETTLE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      quiet_q  <= '0;
      active_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      quiet_q  <= quiet_d;
      active_o <= active_d;
    end
  end

  assign early_in_o  = active_o && in_chg_i;
  assign close_o     = settled || early_in_o;
  assign close_cnt_o = cnt_q;
  assign osc_hit_o   = (in_chg_i || out_chg_i) && (cnt_d > osc_limit_i);
endmodule

// File: rtl/hm_flags.sv
module hm_flags
  import hazmon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             multi_chg_i,
  input  logic             early_in_i,
  input  logic             close_i,
  input  logic [CNT_W-1:0] close_cnt_i,
  input  logic             osc_hit_i,
  output haz_flags_t       flags_o
);
  haz_flags_t set_d;

  always_comb begin
    set_d.mode_viol   = multi_chg_i || early_in_i;
    set_d.static_haz  = close_i && (close_cnt_i >= CNT_W'(2)) && !close_cnt_i[0];
    set_d.dynamic_haz = close_i && (close_cnt_i >= CNT_W'(3)) && close_cnt_i[0];
    set_d.osc         = osc_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (clr_i) flags_o <= '0;
    else            flags_o <= flags_o | set_d;
  end
endmodule

// File: rtl/hazard_monitor.sv
module hazard_monitor
  import hazmon_pkg::*;
#(
  parameter int IN_W     = 4,
  parameter int CNT_W    = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IN_W-1:0]     in_i,
  input  logic                out_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic [CNT_W-1:0]    osc_limit_i,
  input  logic                clr_i,
  output logic                busy_o,
  output logic                mode_viol_o,
  output logic                static_haz_o,
  output logic                dynamic_haz_o,
  output logic                osc_o
);
  logic [IN_W-1:0]  in_prev;
  logic             out_prev, in_chg, multi_chg, out_chg;
  logic             early_in, close_win, osc_hit;
  logic [CNT_W-1:0] close_cnt;
  haz_flags_t       flags;

  hm_edge #(.IN_W(IN_W)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_i        (in_i),
    .out_i       (out_i),
    .in_prev_o   (in_prev),
    .out_prev_o  (out_prev),
    .in_chg_o    (in_chg),
    .multi_chg_o (multi_chg),
    .out_chg_o   (out_chg)
  );

  hm_window #(.CNT_W(CNT_W), .SETTLE_W(SETTLE_W)) u_window (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .in_chg_i        (in_chg),
    .out_chg_i       (out_chg),
    .settle_cycles_i (settle_cycles_i),
    .osc_limit_i     (osc_limit_i),
    .active_o        (busy_o),
    .early_in_o      (early_in),
    .close_o         (close_win),
    .close_cnt_o     (close_cnt),
    .osc_hit_o       (osc_hit)
  );

  hm_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .multi_chg_i (multi_chg),
    .early_in_i  (early_in),
    .close_i     (close_win),
    .close_cnt_i (close_cnt),
    .osc_hit_i   (osc_hit),
    .flags_o     (flags)
  );

  assign mode_viol_o   = flags.mode_viol;
  assign static_haz_o  = flags.static_haz;
  assign dynamic_haz_o = flags.dynamic_haz;
  assign osc_o         = flags.osc;
endmodule

// File: rtl/hazard_monitor_chk.sv
module hazard_monitor_chk #(
  parameter int IN_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [IN_W-1:0] in_i,
  input logic            out_i,
  input logic [IN_W-1:0] in_prev,
  input logic            out_prev,
  input logic            clr_i,
  input logic            busy_o,
  input logic            mode_viol_o,
  input logic            static_haz_o,
  input logic            dynamic_haz_o,
  input logic            osc_o
);
  a_r3_multi_bit_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(in_i ^ in_prev) > 1 && !clr_i) |=> mode_viol_o);

  a_r4_early_input_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && in_i != in_prev && !clr_i) |=> mode_viol_o);

  a_r2_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && in_i == in_prev && out_i == out_prev) |=> !busy_o);

  a_r2_change_opens_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i != in_prev || out_i != out_prev) |=> busy_o);

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !mode_viol_o && !static_haz_o && !dynamic_haz_o && !osc_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_viol_o || static_haz_o || dynamic_haz_o || osc_o) && !clr_i) |=>
      ($past(mode_viol_o) <= mode_viol_o) && ($past(static_haz_o) <= static_haz_o) &&
      ($past(dynamic_haz_o) <= dynamic_haz_o) && ($past(osc_o) <= osc_o));

  a_r5_r6_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(static_haz_o) && $rose(dynamic_haz_o)));
endmodule

bind hazard_monitor hazard_monitor_chk #(.IN_W(IN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_i          (in_i),
  .out_i         (out_i),
  .in_prev       (in_prev),
  .out_prev      (out_prev),
  .clr_i         (clr_i),
  .busy_o        (busy_o),
  .mode_viol_o   (mode_viol_o),
  .static_haz_o  (static_haz_o),
  .dynamic_haz_o (dynamic_haz_o),
  .osc_o         (osc_o)
);

// File: tb/tb_hazard_monitor.sv
module tb_hazard_monitor;
  localparam int IN_W = 4, CNT_W = 4, SETTLE_W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [IN_W-1:0]     in_r = '0;
  logic                out_r = 1'b0;
  logic [SETTLE_W-1:0] settle = 8'd2;
  logic [CNT_W-1:0]    olim = 4'd15;
  logic                clr = 1'b0;
  logic busy, mv, sh, dh, osc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hazard_monitor #(.IN_W(IN_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_r), .out_i(out_r),
    .settle_cycles_i(settle), .osc_limit_i(olim), .clr_i(clr),
    .busy_o(busy), .mode_viol_o(mv), .static_haz_o(sh),
    .dynamic_haz_o(dh), .osc_o(osc));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags(input string req, input logic e_mv, input logic e_sh,
                           input logic e_dh, input logic e_os);
    chk({req, " mode_viol"}, mv, e_mv);
    chk({req, " static"}, sh, e_sh);
    chk({req, " dynamic"}, dh, e_dh);
    chk({req, " osc"}, osc, e_os);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk_flags("R1", 0, 0, 0, 0);
    chk("R1 busy", busy, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 busy after release", busy, 1'b0);

    // R2/R5/R6: sweep settle, toggle count and gap
    for (int s = 1; s <= 3; s++) begin
      settle = SETTLE_W'(s);
      for (int n = 0; n <= 5; n++) begin
        for (int g = 1; g <= s; g++) begin
          in_r[n % IN_W] = ~in_r[n % IN_W];
          for (int k = 0; k < n; k++) begin
            cyc(1);
            out_r = ~out_r;
            if (k < n - 1) cyc(g - 1);
          end
          // last counted change is at the next edge; window closes s edges later
          cyc(s);
          chk("R2 busy before close", busy, 1'b1);
          cyc(1);
          chk("R2 busy after close", busy, 1'b0);
          chk_flags((n >= 3 && n % 2 == 1) ? "R6" : (n >= 2) ? "R5" : "R2",
                    0, (n >= 2 && n % 2 == 0), (n >= 3 && n % 2 == 1), 0);
          do_clear();
        end
      end
    end

    // R3: two bits at once
    settle = 8'd2;
    in_r = in_r ^ 4'b0011; cyc(1);
    chk("R3 multi bit", mv, 1'b1);
    cyc(3); do_clear();
    chk("R3 cleared", mv, 1'b0);
    in_r = in_r ^ 4'b1111; cyc(1);
    chk("R3 four bits", mv, 1'b1);
    cyc(3); do_clear();

    // R4 + R11: two output changes then early input change
    settle = 8'd3;
    in_r[0] = ~in_r[0]; cyc(1);
    chk("R4 no violation yet", mv, 1'b0);
    out_r = ~out_r; cyc(1);
    out_r = ~out_r; cyc(1);
    chk("R11 not classified yet", sh, 1'b0);
    in_r[1] = ~in_r[1]; cyc(1);
    chk("R4 early input", mv, 1'b1);
    chk("R11 early close static", sh, 1'b1);
    chk("R4 window restarted", busy, 1'b1);
    cyc(4); do_clear();

    // R7: osc limit 3, four toggles
    olim = 4'd3; settle = 8'd2;
    in_r[2] = ~in_r[2];
    for (int k = 0; k < 4; k++) begin
      cyc(1);
      if (k == 3) chk("R7 below limit", osc, 1'b0);
      out_r = ~out_r;
    end
    cyc(1);
    chk("R7 over limit", osc, 1'b1);
    cyc(4);
    chk("R7 sticky", osc, 1'b1);
    do_clear();
    chk("R8 cleared", osc, 1'b0);
    olim = 4'd15;

    // R8: clear wins over same-edge set, flags sticky
    in_r = in_r ^ 4'b0101; clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R8 clear wins", mv, 1'b0);
    cyc(3);
    in_r = in_r ^ 4'b0110; cyc(1);
    cyc(5);
    chk("R8 sticky", mv, 1'b1);
    do_clear();

    // R9: spontaneous output changes
    settle = 8'd2;
    out_r = ~out_r; cyc(1);
    chk("R9 opens window", busy, 1'b1);
    cyc(3);
    chk_flags("R9 single", 0, 0, 0, 0);
    out_r = ~out_r; cyc(1);
    out_r = ~out_r; cyc(4);
    chk_flags("R9 pair static", 0, 1, 0, 0);
    do_clear();

    // R10: zero settle acts as one
    settle = 8'd0;
    in_r[3] = ~in_r[3]; out_r = ~out_r; cyc(1);
    chk("R10 busy after open", busy, 1'b1);
    cyc(1);
    chk("R10 closed after one quiet edge", busy, 1'b0);
    chk_flags("R10", 0, 0, 0, 0);

    finish_run();
  end
endmodule